// File: doc/BRIEF.md
# Dual-Group Four-Channel Power Sequencer

This controller switches four supply rails on and off in a fixed order by driving four gate-enable commands. The rails form two redundant pairs. The first pair holds channels A and B, and the second pair holds channels C and D. Each pair has its own active-low enable and its own active-low reset output. The controller reads four undervoltage-good flags and a per-channel "gate fully on" report. Programmable tick counts set the spacing between gate transitions.

A cold start needs every monitor good and both enables low. The monitors must also have stayed good for a stabilisation lockout. The rails then come up in the order A, B, C, D. Each channel's delay starts only when the previous channel reports fully on. Both resets release together, a fixed time after D is fully on.

After start-up the two pairs act independently. A bad monitor drops only its own pair at once. A pair raising its enable shuts down in reverse order, using the off-delays. A pair stopped by a fault runs again only after its own enable has been raised and lowered again.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Out of reset, all four gate commands are 0 and both group resets are 0.
- R2: A level change on any monitor or enable input that lasts fewer than FILT_TICKS ticks changes no output. A change is accepted only after FILT_TICKS consecutive ticks.
- R3: No gate command rises unless all four monitors are good and both enables are low. Gate A does not rise earlier than LOCK_TICKS+FILT_TICKS ticks after the monitors all become good.
- R4: The on-delay of channel k is on_dly_i[k*DLY_W +: DLY_W], and gate_en_o bit k drives channel k (0=A, 1=B, 2=C, 3=D). At cold start the gates rise in the order A, B, C, D. Gate B rises exactly on-delay(B)+2 ticks after the fully-on report of A rises. Gate D rises exactly on-delay(D)+2 ticks after that of C. Gate C rises exactly on-delay(C)+3 ticks after that of B.
- R5: An on-delay or off-delay of zero makes the transition happen at the minimum spacing: 2 ticks for an on-delay within a pair, and 1 tick for an off-delay.
- R6: Group resets stay low while sequencing. At cold start both resets rise on the same tick, RST_TICKS+3 ticks after the fully-on report of D rises. A pair restarted alone releases its reset RST_TICKS+3 ticks after its second channel reports fully on.
- R7: When a monitor of one pair goes bad, that pair's two gates and its reset drop within FILT_TICKS+2 ticks. The other pair's gates and reset do not change.
- R8: A pair stopped by a fault stays off after its monitors recover, for as long as its enable stays low. After its enable goes high and then low again, it re-runs its own two-channel sequence while the other pair keeps running.
- R9: Raising a pair's enable drops that pair's reset and turns off its second gate, then its first. The off-delay of channel k is off_dly_i[k*DLY_W +: DLY_W]. The first gate of the pair falls exactly off-delay(first)+1 ticks after the second gate falls. The other pair is unaffected.
- R10: When both pairs are off, lowering only one enable starts nothing. A cold start in the order A, B, C, D follows once both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 4 | Undervoltage-good flags, bit k for channel k |
| en_n_i | input | 2 | Active-low enables, bit 0 for pair A/B, bit 1 for pair C/D |
| gate_on_i | input | 4 | Gate fully-on reports, bit k for channel k |
| on_dly_i | input | 4*DLY_W | Per-channel on-delays in ticks |
| off_dly_i | input | 4*DLY_W | Per-channel off-delays in ticks |
| gate_en_o | output | 4 | Gate-enable commands, bit k for channel k |
| grp_rst_n_o | output | 2 | Active-low group resets, bit 0 for A/B, bit 1 for C/D |

## Verification
The bench builds the block with FILT_TICKS=4, LOCK_TICKS=40, RST_TICKS=30 and DLY_W=6. These values shrink the 30 µs filter, the 10 ms lockout and the 150 ms reset hold to a few dozen ticks. A cold start, a fault on one pair, a solo restart and a pair of shutdowns all then fit in a few thousand cycles. The bench can then repeat full cycles with random six-bit delays and measure each gate spacing exactly. It can also place glitches exactly one tick shorter than the filter window.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [3:0] {
        GS_OFF,
        GS_DLY0,
        GS_WAIT0,
        GS_DLY1,
        GS_WAIT1,
        GS_HOLD,
        GS_RSTDLY,
        GS_RUN,
        GS_DN1,
        GS_DN0
    } grp_state_e;
endpackage

// File: rtl/seq_filter.sv
module seq_filter #(
    parameter int   TICKS = 1500,
    parameter logic INIT  = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_i,
    output logic out_o
);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d = q;
        if (in_i != q.out) begin
            if (q.cnt == CW'(TICKS - 1)) begin
                d.out = in_i;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.cnt <= '0;
            q.out <= INIT;
        end else begin
            q <= d;
        end
    end

    assign out_o = q.out;

    // R2
    flt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.out != $past(q.out)) |-> ($past(in_i) == q.out));
endmodule

// File: rtl/seq_group.sv
module seq_group
    import seq_pkg::*;
#(
    parameter int DLY_W     = 16,
    parameter int RST_TICKS = 7500000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               uv_ok_i,
    input  logic               en_n_i,
    input  logic [1:0]         fb_i,
    input  logic               rst_go_i,
    input  logic [2*DLY_W-1:0] on_dly_i,
    input  logic [2*DLY_W-1:0] off_dly_i,
    output logic [1:0]         gate_o,
    output logic               rst_n_o,
    output logic               idle_o,
    output logic               done_o,
    output logic               need_cycle_o
);
    localparam int RW = $clog2(RST_TICKS + 1);
    localparam int CW = (DLY_W > RW) ? DLY_W : RW;

    typedef struct packed {
        grp_state_e    state;
        logic [CW-1:0] cnt;
        logic [1:0]    gate;
        logic          rst;
        logic          cyc_req;
    } grp_t;

    grp_t q, d;

    logic [CW-1:0] on0, on1, off0, off1;
    assign on0  = CW'(on_dly_i[0 +: DLY_W]);
    assign on1  = CW'(on_dly_i[DLY_W +: DLY_W]);
    assign off0 = CW'(off_dly_i[0 +: DLY_W]);
    assign off1 = CW'(off_dly_i[DLY_W +: DLY_W]);

    always_comb begin
        d = q;
        case (q.state)
            GS_OFF: begin
                d.gate = 2'b00;
                d.rst  = 1'b0;
                if (en_n_i) d.cyc_req = 1'b0;
                if (start_i) begin
                    d.state = GS_DLY0;
                    d.cnt   = '0;
                end
            end
            GS_DLY0: begin
                if (q.cnt == on0) begin
                    d.state   = GS_WAIT0;
                    d.gate[0] = 1'b1;
                end else d.cnt = q.cnt + 1'b1;
            end
            GS_WAIT0: begin
                if (fb_i[0]) begin
                    d.state = GS_DLY1;
                    d.cnt   = '0;
                end
            end
            GS_DLY1: begin
                if (q.cnt == on1) begin
                    d.state   = GS_WAIT1;
                    d.gate[1] = 1'b1;
                end else d.cnt = q.cnt + 1'b1;
            end
            GS_WAIT1: begin
                if (fb_i[1]) d.state = GS_HOLD;
            end
            GS_HOLD: begin
                if (rst_go_i) begin
                    d.state = GS_RSTDLY;
                    d.cnt   = '0;
                end
            end
            GS_RSTDLY: begin
                if (q.cnt == CW'(RST_TICKS)) begin
                    d.state = GS_RUN;
                    d.rst   = 1'b1;
                end else d.cnt = q.cnt + 1'b1;
            end
            GS_RUN: ;
            GS_DN1: begin
                if (q.cnt == off1) begin
                    d.state   = GS_DN0;
                    d.gate[1] = 1'b0;
                    d.cnt     = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            GS_DN0: begin
                if (q.cnt == off0) begin
                    d.state   = GS_OFF;
                    d.gate[0] = 1'b0;
                end else d.cnt = q.cnt + 1'b1;
            end
            default: d.state = GS_OFF;
        endcase

        // normal shutdown request from any powering or running state
        if (en_n_i && (q.state inside {GS_DLY0, GS_WAIT0, GS_DLY1, GS_WAIT1,
                                       GS_HOLD, GS_RSTDLY, GS_RUN})) begin
            d.state = GS_DN1;
            d.cnt   = '0;
            d.rst   = 1'b0;
        end

        // fault overrides everything
        if (q.state != GS_OFF && !uv_ok_i) begin
            d.state   = GS_OFF;
            d.gate    = 2'b00;
            d.rst     = 1'b0;
            d.cyc_req = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state   <= GS_OFF;
            q.cnt     <= '0;
            q.gate    <= 2'b00;
            q.rst     <= 1'b0;
            q.cyc_req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign gate_o       = q.gate;
    assign rst_n_o      = q.rst;
    assign idle_o       = (q.state == GS_OFF);
    assign done_o       = (q.state inside {GS_HOLD, GS_RSTDLY, GS_RUN});
    assign need_cycle_o = q.cyc_req;

    // R9
    gate_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.gate[1] |-> q.gate[0]);

    // R6
    rst_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.rst |-> (q.gate == 2'b11));

    // R7
    fault_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !uv_ok_i |=> (q.gate == 2'b00 && !q.rst));

    // R8
    restart_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == GS_OFF && q.cyc_req && !en_n_i) |=> (q.state == GS_OFF));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int FILT_TICKS = 1500,
    parameter int LOCK_TICKS = 500000,
    parameter int RST_TICKS  = 7500000,
    parameter int DLY_W      = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [3:0]         uv_ok_i,
    input  logic [1:0]         en_n_i,
    input  logic [3:0]         gate_on_i,
    input  logic [4*DLY_W-1:0] on_dly_i,
    input  logic [4*DLY_W-1:0] off_dly_i,
    output logic [3:0]         gate_en_o,
    output logic [1:0]         grp_rst_n_o
);
    localparam int NCH = 4;
    localparam int NGR = 2;
    localparam int LW  = $clog2(LOCK_TICKS + 1);

    logic [NCH-1:0] uv_f;
    logic [NGR-1:0] en_f;
    logic [NGR-1:0] grp_idle, grp_done, grp_need, grp_ok, ready, start, rst_go;
    logic           all_ok, lock_done, joint_go;
    logic [NGR-1:0] solo_go;

    for (genvar k = 0; k < NCH; k++) begin : g_uvf
        seq_filter #(.TICKS(FILT_TICKS), .INIT(1'b0)) i_flt (
            .clk_i(clk_i), .rst_ni(rst_ni), .in_i(uv_ok_i[k]), .out_o(uv_f[k]));
    end
    for (genvar g = 0; g < NGR; g++) begin : g_enf
        seq_filter #(.TICKS(FILT_TICKS), .INIT(1'b1)) i_flt (
            .clk_i(clk_i), .rst_ni(rst_ni), .in_i(en_n_i[g]), .out_o(en_f[g]));
    end

    typedef struct packed {
        logic [LW-1:0] lock;
        logic          joint_pend;
        logic          joint_ab;
    } top_t;

    top_t q, d;

    assign all_ok    = &uv_f;
    assign lock_done = (q.lock == LW'(LOCK_TICKS));

    always_comb begin
        for (int g = 0; g < NGR; g++) begin
            grp_ok[g] = &uv_f[2*g +: 2];
            ready[g]  = grp_idle[g] & grp_ok[g] & ~en_f[g] & ~grp_need[g];
        end
        joint_go   = lock_done & all_ok & (&ready) & ~q.joint_pend;
        solo_go[0] = lock_done & ready[0] & ~grp_idle[1] & ~q.joint_pend;
        solo_go[1] = lock_done & ready[1] & ~grp_idle[0] & ~q.joint_pend;
        start[0]   = joint_go | solo_go[0];
        start[1]   = (q.joint_pend & grp_done[0] & ready[1]) | solo_go[1];
        rst_go[0]  = ~q.joint_ab | grp_done[1] | (grp_idle[1] & ~q.joint_pend);
        rst_go[1]  = 1'b1;

        d = q;
        if (!all_ok) d.lock = '0;
        else if (!lock_done) d.lock = q.lock + 1'b1;

        if (joint_go) d.joint_pend = 1'b1;
        else if (grp_done[0] | grp_idle[0]) d.joint_pend = 1'b0;

        if (joint_go) d.joint_ab = 1'b1;
        else if (grp_idle[0]) d.joint_ab = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.lock       <= '0;
            q.joint_pend <= 1'b0;
            q.joint_ab   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NGR; g++) begin : g_grp
        seq_group #(.DLY_W(DLY_W), .RST_TICKS(RST_TICKS)) i_grp (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .start_i     (start[g]),
            .uv_ok_i     (grp_ok[g]),
            .en_n_i      (en_f[g]),
            .fb_i        (gate_on_i[2*g +: 2]),
            .rst_go_i    (rst_go[g]),
            .on_dly_i    (on_dly_i[2*g*DLY_W +: 2*DLY_W]),
            .off_dly_i   (off_dly_i[2*g*DLY_W +: 2*DLY_W]),
            .gate_o      (gate_en_o[2*g +: 2]),
            .rst_n_o     (grp_rst_n_o[g]),
            .idle_o      (grp_idle[g]),
            .done_o      (grp_done[g]),
            .need_cycle_o(grp_need[g])
        );
    end

    // R4
    c_after_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(gate_en_o[2]) && q.joint_ab) |-> gate_on_i[1]);

    // R3
    start_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(gate_en_o[0]) && !gate_en_o[2]) |-> grp_ok[0]);
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    localparam int FILT = 4;
    localparam int LOCK = 40;
    localparam int RSTT = 30;
    localparam int DW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    uv = 4'h0;
    logic [1:0]    en_n = 2'b11;
    logic [3:0]    fb = 4'h0;
    logic [4*DW-1:0] on_dly = '0;
    logic [4*DW-1:0] off_dly = '0;
    logic [3:0]    gate;
    logic [1:0]    grst;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;
    int cyc = 0;
    int t_gr[4], t_gf[4], t_fr[4], t_rr[2];
    logic [3:0] pg = 4'h0, pf = 4'h0;
    logic [1:0] pr = 2'b00;

    pwr_seq_ctrl #(.FILT_TICKS(FILT), .LOCK_TICKS(LOCK), .RST_TICKS(RSTT), .DLY_W(DW)) i_pwr_seq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .uv_ok_i(uv), .en_n_i(en_n), .gate_on_i(fb),
        .on_dly_i(on_dly), .off_dly_i(off_dly), .gate_en_o(gate), .grp_rst_n_o(grst));

    always #10 clk = ~clk;

    // switch model: reports fully on one tick after the command
    always @(posedge clk) fb <= gate;

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < 4; i++) begin
            if (gate[i] && !pg[i]) t_gr[i] = cyc;
            if (!gate[i] && pg[i]) t_gf[i] = cyc;
            if (fb[i] && !pf[i]) t_fr[i] = cyc;
        end
        for (int g = 0; g < 2; g++) if (grst[g] && !pr[g]) t_rr[g] = cyc;
        pg = gate; pf = fb; pr = grst;
    end

    function automatic int gap_on(int dly);   return dly + 2; endfunction
    function automatic int gap_cross(int dly); return dly + 3; endfunction
    function automatic int gap_rst();          return RSTT + 3; endfunction
    function automatic int gap_off(int dly);  return dly + 1; endfunction
    function automatic int dly_of(logic [4*DW-1:0] v, int k); return int'(v[k*DW +: DW]); endfunction

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_gate(int i, logic v, string req);
        int n = 0;
        while (gate[i] !== v && n < 2000) begin tick(); n++; end
        if (gate[i] !== v) chk({req, " timeout gate"}, int'(gate[i]), int'(v));
    endtask

    task automatic wait_rst(int g, logic v, string req);
        int n = 0;
        while (grst[g] !== v && n < 2000) begin tick(); n++; end
        if (grst[g] !== v) chk({req, " timeout reset"}, int'(grst[g]), int'(v));
    endtask

    task automatic check_cold_start(string req);
        wait_rst(0, 1'b1, req);
        wait_rst(1, 1'b1, req);
        chk({req, " order A<B"}, int'(t_gr[0] < t_gr[1]), 1);
        chk({req, " order B<C"}, int'(t_gr[1] < t_gr[2]), 1);
        chk({req, " order C<D"}, int'(t_gr[2] < t_gr[3]), 1);
        chk({req, " gap B"}, t_gr[1] - t_fr[0], gap_on(dly_of(on_dly, 1)));
        chk({req, " gap C"}, t_gr[2] - t_fr[1], gap_cross(dly_of(on_dly, 2)));
        chk({req, " gap D"}, t_gr[3] - t_fr[2], gap_on(dly_of(on_dly, 3)));
        chk("R6 reset AB after D", t_rr[0] - t_fr[3], gap_rst());
        chk("R6 reset CD after D", t_rr[1] - t_fr[3], gap_rst());
    endtask

    task automatic shut_both(string req);
        en_n = 2'b11;
        wait_gate(0, 1'b0, req);
        wait_gate(2, 1'b0, req);
        chk({req, " AB reverse gap"}, t_gf[0] - t_gf[1], gap_off(dly_of(off_dly, 0)));
        chk({req, " CD reverse gap"}, t_gf[2] - t_gf[3], gap_off(dly_of(off_dly, 2)));
        chk({req, " resets low"}, int'(grst), 0);
        tick(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t_uv;
        void'($urandom(32'd4711));
        on_dly  = {6'd5, 6'd3, 6'd7, 6'd2};
        off_dly = {6'd4, 6'd6, 6'd2, 6'd9};
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1
        chk("R1 gates after reset", int'(gate), 0);
        chk("R1 resets after reset", int'(grst), 0);

        // R3: enables low but monitors bad
        en_n = 2'b00;
        tick(100);
        chk("R3 no start with bad monitors", int'(gate), 0);
        uv = 4'hF;
        t_uv = cyc;
        wait_gate(0, 1'b1, "R3");
        chk("R3 lockout respected", int'((t_gr[0] - t_uv) >= LOCK + FILT), 1);
        check_cold_start("R4");

        // R2 glitches
        uv[0] = 1'b0; tick(FILT - 1); uv[0] = 1'b1;
        tick(20);
        chk("R2 monitor glitch ignored gates", int'(gate), 15);
        chk("R2 monitor glitch ignored resets", int'(grst), 3);
        en_n[1] = 1'b1; tick(FILT - 1); en_n[1] = 1'b0;
        tick(20);
        chk("R2 enable glitch ignored gates", int'(gate), 15);
        chk("R2 enable glitch ignored resets", int'(grst), 3);

        // R7 fault on C
        uv[2] = 1'b0;
        tick(FILT + 3);
        chk("R7 CD gates dropped", int'(gate[3:2]), 0);
        chk("R7 CD reset dropped", int'(grst[1]), 0);
        chk("R7 AB gates kept", int'(gate[1:0]), 3);
        chk("R7 AB reset kept", int'(grst[0]), 1);

        // R8 recovery needs enable cycling
        uv[2] = 1'b1;
        tick(LOCK + FILT + 60);
        chk("R8 no restart without cycling", int'(gate[3:2]), 0);
        en_n[1] = 1'b1; tick(FILT + 6); en_n[1] = 1'b0;
        wait_rst(1, 1'b1, "R8");
        chk("R8 solo gap D", t_gr[3] - t_fr[2], gap_on(dly_of(on_dly, 3)));
        chk("R6 solo reset", t_rr[1] - t_fr[3], gap_rst());
        chk("R8 AB untouched", int'(gate[1:0]), 3);

        // R9 normal shutdown of AB only
        en_n[0] = 1'b1;
        wait_gate(0, 1'b0, "R9");
        chk("R9 B off before A", int'(t_gf[1] < t_gf[0]), 1);
        chk("R9 reverse gap", t_gf[0] - t_gf[1], gap_off(dly_of(off_dly, 0)));
        chk("R9 AB reset low", int'(grst[0]), 0);
        chk("R9 CD untouched gates", int'(gate[3:2]), 3);
        chk("R9 CD untouched reset", int'(grst[1]), 1);

        // R9 then shut CD
        en_n[1] = 1'b1;
        wait_gate(2, 1'b0, "R9");
        chk("R9 CD reverse gap", t_gf[2] - t_gf[3], gap_off(dly_of(off_dly, 2)));
        tick(10);

        // R10 one enable only
        en_n[0] = 1'b0;
        tick(200);
        chk("R10 single enable starts nothing", int'(gate), 0);
        // R5 zero delays
        on_dly = '0; off_dly = '0;
        en_n[1] = 1'b0;
        wait_gate(0, 1'b1, "R10");
        check_cold_start("R5");
        shut_both("R5");

        // random delays
        for (int it = 0; it < 4; it++) begin
            on_dly  = 24'($urandom);
            off_dly = 24'($urandom);
            en_n = 2'b00;
            wait_gate(0, 1'b1, "R4");
            check_cold_start("R4");
            shut_both("R9");
        end

        done_flag = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule